// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block places a direct-mapped cache between a processor load/store port and a main memory port that moves one 32-bit word per beat. Each byte address is cut into three fields: word offset, row index and tag. Every row holds a valid flag, a dirty flag, a stored tag and a block of `WORDS` 32-bit words. Reads that hit are answered from the row. A read miss holds the processor off, fetches the whole block, then returns the requested word.

Two elaboration-time switches set the write behaviour. The write-hit switch selects either write-back, where a dirty row is flushed to memory only when another block replaces it, or write-through, where every write also reaches memory. The write-miss switch selects either allocate, where the block is fetched first and the write then merges into it, or bypass, where the write goes straight to memory.

Both sides use valid/ready handshakes. The processor may hold `cpu_req_valid` high for as long as it likes. The request is taken on the first cycle in which `cpu_req_ready` is also high. That happens only while the controller is idle, so the cache accepts one access at a time. A memory beat completes in any cycle where `mem_req_valid` and `mem_req_ready` are both high. For a read beat, `mem_rsp_rdata` must be valid in that same cycle. While memory holds `mem_req_ready` low, the controller keeps every request field unchanged. Two counters report how many accesses hit and how many missed.

Top module: `dm_cache`

## Requirements
- R1: After reset every row is invalid, both counters read zero, `cpu_req_ready` is high and no memory request is raised, so the first access to any block misses.
- R2: Address bits [1:0] are ignored, because all accesses are whole words. Bits [OFF_W-1:2] pick the word in the block, the next IDX_W bits pick the row (the block address modulo ROWS), and the remaining upper bits form the tag.
- R3: A read hit returns the stored word without any memory traffic and adds one to `hit_count`.
- R4: A read miss adds one to `miss_count`. It fetches the block as WORDS read beats, starting at word 0 with the address rising by 4 per beat, and then returns the requested word.
- R5: An access whose tag differs from the tag in a valid row replaces that row's block, so a later access to the old block misses.
- R6: With write-back, a write hit changes only the cache. When a dirty row is replaced, its WORDS words are first written to memory at the old block's addresses.
- R7: With write-through, every write produces exactly one memory write beat, rows never become dirty, and memory always holds the latest written data.
- R8: With write-allocate, a write miss fetches the block and then completes as a write hit.
- R9: With no-write-allocate, a write miss produces one memory write beat and leaves the cache unchanged, so a later read of that block still misses.
- R10: Each accepted request gives exactly one single-cycle `cpu_rsp_valid` pulse, after which `cpu_req_ready` returns high. While `mem_req_ready` is low, a raised memory request keeps its address, data and direction unchanged.
- R11: Every access adds exactly one to either `hit_count` or `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle and able to take a request |
| cpu_req_we | input | 1 | 1 for a store, 0 for a load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Load data, valid when `cpu_rsp_valid` is high |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_req_ready | input | 1 | Memory accepts the beat (read data valid) |
| mem_req_we | output | 1 | 1 for a write beat |
| mem_req_addr | output | 32 | Word-aligned beat address |
| mem_req_wdata | output | 32 | Write beat data |
| mem_rsp_rdata | input | 32 | Read beat data |
| hit_count | output | CNT_W | Accesses that hit |
| miss_count | output | CNT_W | Accesses that missed |

## Verification
A wrong valid flag or stored tag shows up at the ports in two ways. A hit counted as a miss moves the wrong counter, and a missing four-beat read burst shows up on the memory port during the same access. A lost dirty flag or a corrupted data word produces no symptom until the row is replaced and the block is read again. For that reason every read is compared with an architectural shadow of memory, and every block is read back at the end. The per-access count of memory beats exposes bad eviction or write-through behaviour as soon as the offending access completes.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WRMEM
  } dmc_state_e;

  // word-select width, never zero so single-word blocks still have a field
  function automatic int wsel_width(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 4,
  parameter int TAG_W  = 20,
  parameter int WSEL_W = 2
) (
  input  logic [29:0]       waddr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [WSEL_W-1:0] wsel
);
  localparam int WOFF = OFF_W - 2;

  assign idx = waddr[WOFF +: IDX_W];
  assign tag = waddr[29 -: TAG_W];

  generate
    if (WOFF > 0) begin : g_multi_word
      assign wsel = waddr[WOFF-1:0];
    end else begin : g_single_word
      assign wsel = '0;
    end
  endgenerate
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int WORDS  = 4,
  parameter int ROWS   = 256,
  parameter int TAG_W  = 20,
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [31:0]       rd_word,
  input  logic              wr_word_en,
  input  logic [WSEL_W-1:0] wr_wsel,
  input  logic [31:0]       wr_wdata,
  input  logic              meta_en,
  input  logic [TAG_W-1:0]  meta_tag,
  input  logic              dirty_set
);
  logic [ROWS-1:0]  valid_q;
  logic [ROWS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q  [ROWS];
  logic [31:0]      data_q [ROWS][WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (meta_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (meta_en) tag_q[idx] <= meta_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_word_en) data_q[idx][wr_wsel] <= wr_wdata;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_word  = data_q[idx][rd_wsel];

  // a refill that installs a row and a store that dirties it never coincide (R6)
  p_meta_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(meta_en && dirty_set));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter int TAG_W       = 20,
  parameter int IDX_W       = 8,
  parameter int OFF_W       = 4,
  parameter int WSEL_W      = 2,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [29:0]       cpu_req_waddr,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rsp_rdata,
  output logic [29:0]       req_waddr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WSEL_W-1:0] req_wsel,
  input  logic              st_valid,
  input  logic              st_dirty,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [31:0]       st_word,
  output logic [WSEL_W-1:0] st_wsel,
  output logic              wr_word_en,
  output logic [WSEL_W-1:0] wr_wsel,
  output logic [31:0]       wr_wdata,
  output logic              meta_en,
  output logic              dirty_set,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              hit_pulse,
  output logic              miss_pulse
);
  dmc_state_e        state, nxt_state;
  logic              r_we;
  logic [29:0]       r_waddr;
  logic [31:0]       r_wdata;
  logic [WSEL_W-1:0] beat;
  logic              post_fill;
  logic              rsp_set;
  logic [31:0]       rsp_word;
  logic              hit, last_beat, beat_done, need_evict;
  logic [TAG_W-1:0]  blk_tag;
  logic [31:0]       blk_base;

  assign req_waddr     = r_waddr;
  assign hit           = st_valid && (st_tag == req_tag);
  assign last_beat     = (beat == WSEL_W'(WORDS - 1));
  assign beat_done     = mem_req_valid && mem_req_ready;
  assign need_evict    = WRITE_BACK && st_valid && st_dirty;
  assign cpu_req_ready = (state == ST_IDLE);

  // memory side
  assign mem_req_valid = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WRMEM);
  assign mem_req_we    = (state != ST_FILL);
  assign blk_tag       = (state == ST_EVICT) ? st_tag : req_tag;
  assign blk_base      = {blk_tag, req_idx, {OFF_W{1'b0}}};
  assign mem_req_addr  = (state == ST_WRMEM) ? {r_waddr, 2'b00}
                                             : (blk_base | (32'(beat) << 2));
  assign mem_req_wdata = (state == ST_EVICT) ? st_word : r_wdata;

  // store side
  assign st_wsel  = (state == ST_EVICT) ? beat : req_wsel;
  assign wr_wsel  = (state == ST_FILL) ? beat : req_wsel;
  assign wr_wdata = (state == ST_FILL) ? mem_rsp_rdata : r_wdata;
  assign rsp_word = r_we ? 32'd0 : st_word;

  always_comb begin
    nxt_state  = state;
    wr_word_en = 1'b0;
    meta_en    = 1'b0;
    dirty_set  = 1'b0;
    hit_pulse  = 1'b0;
    miss_pulse = 1'b0;
    rsp_set    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpu_req_valid) nxt_state = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit) begin
          hit_pulse = !post_fill;
          if (!r_we) begin
            rsp_set   = 1'b1;
            nxt_state = ST_IDLE;
          end else begin
            wr_word_en = 1'b1;
            if (WRITE_BACK) begin
              dirty_set = 1'b1;
              rsp_set   = 1'b1;
              nxt_state = ST_IDLE;
            end else begin
              nxt_state = ST_WRMEM;
            end
          end
        end else begin
          miss_pulse = 1'b1;
          if (r_we && !WRITE_ALLOC) nxt_state = ST_WRMEM;
          else if (need_evict)      nxt_state = ST_EVICT;
          else                      nxt_state = ST_FILL;
        end
      end
      ST_EVICT: begin
        if (beat_done && last_beat) nxt_state = ST_FILL;
      end
      ST_FILL: begin
        wr_word_en = beat_done;
        if (beat_done && last_beat) begin
          meta_en   = 1'b1;
          nxt_state = ST_LOOKUP;
        end
      end
      ST_WRMEM: begin
        if (beat_done) begin
          rsp_set   = 1'b1;
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      r_we          <= 1'b0;
      r_waddr       <= '0;
      r_wdata       <= '0;
      beat          <= '0;
      post_fill     <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      state         <= nxt_state;
      cpu_rsp_valid <= rsp_set;
      if (rsp_set) cpu_rsp_rdata <= rsp_word;
      if (state == ST_IDLE && cpu_req_valid) begin
        r_we    <= cpu_req_we;
        r_waddr <= cpu_req_waddr;
        r_wdata <= cpu_req_wdata;
      end
      if (state != nxt_state) beat <= '0;
      else if (beat_done)     beat <= beat + 1'b1;
      if (meta_en)                  post_fill <= 1'b1;
      else if (state == ST_LOOKUP)  post_fill <= 1'b0;
    end
  end

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_we)));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // the row just refilled must match the pending request (R4)
  p_fill_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOKUP && post_fill) |-> (st_valid && st_tag == req_tag));

  generate
    if (!WRITE_BACK) begin : g_wt_check
      p_wt_clean_r7: assert property (@(posedge clk) disable iff (rst)
        !st_dirty);
    end
  endgenerate
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter int ROWS        = 256,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req_valid,
  output logic             cpu_req_ready,
  input  logic             cpu_req_we,
  input  logic [31:0]      cpu_req_addr,
  input  logic [31:0]      cpu_req_wdata,
  output logic             cpu_rsp_valid,
  output logic [31:0]      cpu_rsp_rdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [31:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic [31:0]      mem_rsp_rdata,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int OFF_W  = $clog2(WORDS) + 2;
  localparam int IDX_W  = $clog2(ROWS);
  localparam int TAG_W  = 32 - OFF_W - IDX_W;
  localparam int WSEL_W = wsel_width(WORDS);

  logic              unused_lsbs;
  logic [29:0]       req_waddr;
  logic [TAG_W-1:0]  req_tag, st_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel, st_wsel, wr_wsel;
  logic              st_valid, st_dirty;
  logic [31:0]       st_word, wr_wdata;
  logic              wr_word_en, meta_en, dirty_set;
  logic              hit_pulse, miss_pulse;

  assign unused_lsbs = ^cpu_req_addr[1:0];

  dmc_addr_split #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)
  ) u_split (
    .waddr(req_waddr),
    .tag  (req_tag),
    .idx  (req_idx),
    .wsel (req_wsel)
  );

  dmc_store #(
    .WORDS(WORDS), .ROWS(ROWS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .idx       (req_idx),
    .rd_wsel   (st_wsel),
    .rd_valid  (st_valid),
    .rd_dirty  (st_dirty),
    .rd_tag    (st_tag),
    .rd_word   (st_word),
    .wr_word_en(wr_word_en),
    .wr_wsel   (wr_wsel),
    .wr_wdata  (wr_wdata),
    .meta_en   (meta_en),
    .meta_tag  (req_tag),
    .dirty_set (dirty_set)
  );

  dmc_ctrl #(
    .WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W),
    .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cpu_req_valid(cpu_req_valid),
    .cpu_req_ready(cpu_req_ready),
    .cpu_req_we   (cpu_req_we),
    .cpu_req_waddr(cpu_req_addr[31:2]),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .req_waddr    (req_waddr),
    .req_tag      (req_tag),
    .req_idx      (req_idx),
    .req_wsel     (req_wsel),
    .st_valid     (st_valid),
    .st_dirty     (st_dirty),
    .st_tag       (st_tag),
    .st_word      (st_word),
    .st_wsel      (st_wsel),
    .wr_word_en   (wr_word_en),
    .wr_wsel      (wr_wsel),
    .wr_wdata     (wr_wdata),
    .meta_en      (meta_en),
    .dirty_set    (dirty_set),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_rdata(mem_rsp_rdata),
    .hit_pulse    (hit_pulse),
    .miss_pulse   (miss_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      hit_count  <= hit_count + CNT_W'(hit_pulse);
      miss_count <= miss_count + CNT_W'(miss_pulse);
    end
  end

  // a counted miss always leaves with memory traffic in progress (R11)
  p_miss_mem_r11: assert property (@(posedge clk) disable iff (rst)
    (miss_count != $past(miss_count)) |-> mem_req_valid);

  // the two counters never advance together (R11)
  p_one_count_r11: assert property (@(posedge clk) disable iff (rst)
    !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

// File: tb/dm_cache_tb.sv
module dmc_harness #(
  parameter bit WB   = 1'b1,
  parameter bit WA   = 1'b1,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst,
  output int   tests,
  output int   fails,
  output logic done
);
  logic        cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [31:0] cpu_req_addr, cpu_req_wdata, cpu_rsp_rdata;
  logic        cpu_rsp_valid;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic [31:0] hit_count, miss_count;

  logic [31:0] mem    [64];
  logic [31:0] golden [64];
  bit          rv [4];
  bit          rdty [4];
  int          rt [4];
  int          rd_beats, wr_beats;

  dm_cache #(.WORDS(4), .ROWS(4), .WRITE_BACK(WB), .WRITE_ALLOC(WA)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_rdata(mem_rsp_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE0000 ^ (i * 32'h00010101);
  endfunction

  // memory model with random stalls
  assign mem_rsp_rdata = mem[mem_req_addr[7:2]];
  always @(negedge clk) mem_req_ready <= (($urandom % 3) != 0);
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      rd_beats <= 0;
      wr_beats <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[7:2]] <= mem_req_wdata;
        wr_beats <= wr_beats + 1;
      end else begin
        rd_beats <= rd_beats + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (cfg wb=%0d wa=%0d): actual %h expected %h", req, WB, WA, act, exp);
    end
  endtask

  // one access, checked against the reference model
  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    int w = int'(addr[7:2]);
    int ix = int'(addr[5:4]);
    int tg = int'(addr[7:6]);
    bit hit = rv[ix] && (rt[ix] == tg);
    int e_rd = 0, e_wr = 0;
    int h0, m0, r0, w0;
    logic [31:0] e_data = golden[w];
    string lbl;
    if (!we || WA) begin
      if (!hit) begin
        if (WB && rv[ix] && rdty[ix]) e_wr = 4;
        e_rd = 4;
        rv[ix] = 1; rt[ix] = tg; rdty[ix] = 0;
      end
    end
    if (we) begin
      golden[w] = wd;
      if (hit || WA) begin
        if (WB) rdty[ix] = 1;
        else e_wr += 1;
      end else begin
        e_wr = 1;
      end
      lbl = !hit ? (WA ? "R8" : "R9") : (WB ? "R6" : "R7");
    end else begin
      lbl = (e_wr != 0) ? "R6" : (hit ? "R3" : "R4");
    end
    h0 = int'(hit_count); m0 = int'(miss_count);
    r0 = rd_beats; w0 = wr_beats;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    if (!we) chk(hit ? "R3 read data" : "R4 read data", cpu_rsp_rdata, e_data);
    chk("R11 hit delta", 32'(int'(hit_count) - h0), hit ? 32'd1 : 32'd0);
    chk("R11 miss delta", 32'(int'(miss_count) - m0), hit ? 32'd0 : 32'd1);
    chk({lbl, " read beats"}, 32'(rd_beats - r0), 32'(e_rd));
    chk({lbl, " write beats"}, 32'(wr_beats - w0), 32'(e_wr));
    @(negedge clk);
    chk("R10 pulse/ready", {30'd0, cpu_rsp_valid, cpu_req_ready}, 32'd1);
  endtask

  initial begin
    int trace [8] = '{0, 1, 2, 3, 4, 3, 4, 15};
    tests = 0; fails = 0; done = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    void'($urandom(SEED));
    for (int i = 0; i < 64; i++) golden[i] = init_word(i);
    for (int i = 0; i < 4; i++) begin rv[i] = 0; rdty[i] = 0; rt[i] = 0; end
    @(negedge clk);
    while (rst) @(negedge clk);
    // R1: reset state
    chk("R1 ready", {31'd0, cpu_req_ready}, 32'd1);
    chk("R1 hit_count", hit_count, 32'd0);
    chk("R1 miss_count", miss_count, 32'd0);
    chk("R1 no mem req", {31'd0, mem_req_valid}, 32'd0);
    // R5/R11: block trace 0,1,2,3,4,3,4,15 gives 2 hits and 6 misses
    for (int k = 0; k < 8; k++) access(1'b0, 32'(trace[k] * 16 + (k % 4) * 4), 32'd0);
    chk("R5 trace hits", hit_count, 32'd2);
    chk("R5 trace misses", miss_count, 32'd6);
    // R2: low address bits ignored, same word returned
    access(1'b0, 32'h0000_00F7, 32'd0);
    chk("R2 byte lane ignored", cpu_rsp_rdata, golden[61]);
    // R6/R8/R9: write, evict via conflicting block, read back
    access(1'b1, 32'h0000_0008, 32'h1234_5678);
    access(1'b0, 32'h0000_0048, 32'd0);
    access(1'b0, 32'h0000_0008, 32'd0);
    // random mix
    for (int n = 0; n < 300; n++)
      access(1'(($urandom % 5) < 2), 32'($urandom % 256), $urandom);
    // R7: write-through keeps memory current
    if (!WB)
      for (int i = 0; i < 64; i++) chk("R7 memory image", mem[i], golden[i]);
    // full read-back through the cache
    for (int i = 0; i < 64; i++) access(1'b0, 32'(i * 4), 32'd0);
    done = 1'b1;
  end
endmodule

module dm_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   t0, f0, t1, f1, t2, f2, t3, f3;
  logic d0, d1, d2, d3;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmc_harness #(.WB(1'b1), .WA(1'b1), .SEED(11)) h_wb_wa (.clk(clk), .rst(rst), .tests(t0), .fails(f0), .done(d0));
  dmc_harness #(.WB(1'b1), .WA(1'b0), .SEED(22)) h_wb_na (.clk(clk), .rst(rst), .tests(t1), .fails(f1), .done(d1));
  dmc_harness #(.WB(1'b0), .WA(1'b1), .SEED(33)) h_wt_wa (.clk(clk), .rst(rst), .tests(t2), .fails(f2), .done(d2));
  dmc_harness #(.WB(1'b0), .WA(1'b0), .SEED(44)) h_wt_na (.clk(clk), .rst(rst), .tests(t3), .fails(f3), .done(d3));

  initial begin
    int cyc = 0;
    int tot_t, tot_f;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    while (!(d0 && d1 && d2 && d3) && cyc < MAX_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    tot_t = t0 + t1 + t2 + t3;
    tot_f = f0 + f1 + f2 + f3;
    if (!(d0 && d1 && d2 && d3)) begin
      tot_t++;
      tot_f++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tot_t, tot_f);
    $finish;
  end
endmodule